// File: doc/BRIEF.md
# Descriptor Submit Queue Register File

This block is a small register file that stages up to eight 64-bit work descriptors before they go to a downstream execution engine. Software reaches it over a simple 32-bit register bus. A descriptor can be placed in two ways. The sequential port writes consecutive slots and wraps around after the last one. The direct window gives every slot a fixed pair of 32-bit words that can be read and written.

A separate load command copies the whole queue into an output snapshot. The snapshot leaves through a valid/ready stream. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the snapshot and its mask are held unchanged. A load that arrives during that time is remembered and carried out in the cycle of the handshake. Loading never clears the slots, so old descriptors stay in place until software overwrites them. A zero descriptor marks a slot as unused, and the output carries a per-slot "in use" mask.

Top module: `desc_stage_queue`

## Requirements
- R1: After reset, every slot reads 0, the sequential pointer is at slot 0 and `out_valid` is 0.
- R2: A write to byte offset 0x500 stages a lower word. A write to 0x504 stores {written word, staged lower word} into the slot at the sequential pointer and then advances the pointer in the order 0,1,…,7,0.
- R3: Writes to 0x500 and writes to the direct window do not move the sequential pointer.
- R4: In the direct window, the lower word of slot n sits at byte offset 0x510+8n and the upper word at 0x514+8n. Both can be read and written. Read data appears on `bus_rdata` in the cycle after `bus_rd_en`.
- R5: At offset 0x550, writing a value with bit 0 = 1 requests a load, and a value with bit 0 = 0 has no effect. Reads of 0x550, 0x500 and 0x504 return 0.
- R6: A load taken at a clock edge copies slot n into `out_data[64n+63:64n]` and raises `out_valid` after that edge. The slots keep their contents.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_used` stay stable. After a handshake edge, `out_valid` falls unless a load is taken at that same edge.
- R8: A load requested while a snapshot is pending is held. It is performed at the handshake edge, using the slot contents at that time. Several held requests collapse into one.
- R9: `out_used[n]` is 1 exactly when snapshot slot n is nonzero.
- R10: Writes to unmapped or non-word-aligned offsets change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd_en` |
| out_valid | output | 1 | Snapshot available |
| out_ready | input | 1 | Engine accepts snapshot |
| out_data | output | 512 | Snapshot, slot n at bits 64n+63:64n |
| out_used | output | 8 | Nonzero-slot mask of the snapshot |

## Verification
The hardest case to reach is a load that arrives while a snapshot is stalled, followed by a change to a slot before the engine accepts. To reach it, the stimulus holds `out_ready` low, issues a second load, and rewrites one slot through the window. It then gives a single-cycle ready. The bench expects `out_valid` to stay high with the rewritten descriptor in the new snapshot, and expects exactly one further snapshot after that.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int WORD_W = 32;
  localparam int DESC_W = 64;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SEQ_LO,
    OP_SEQ_HI,
    OP_WIN,
    OP_LOAD
  } dsq_op_e;
endpackage

// File: rtl/dsq_bus_decode.sv
module dsq_bus_decode
  import dsq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 8,
  parameter logic [ADDR_W-1:0] SEQ_LO_OFS = 'h500,
  parameter logic [ADDR_W-1:0] SEQ_HI_OFS = 'h504,
  parameter logic [ADDR_W-1:0] WIN_OFS    = 'h510,
  parameter logic [ADDR_W-1:0] LOAD_OFS   = 'h550,
  localparam int WIN_WORDS  = 2 * NUM_SLOTS,
  localparam int WORD_IDX_W = $clog2(WIN_WORDS)
) (
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output dsq_op_e               wr_op,
  output logic [WORD_IDX_W-1:0] word_idx,
  output logic                  rd_win
);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(4 * WIN_WORDS);

  logic [ADDR_W-1:0] rel;
  logic              aligned;
  logic              in_win;

  always_comb begin
    rel      = addr - WIN_OFS;
    aligned  = (addr[1:0] == 2'b00);
    in_win   = aligned && (rel < WIN_BYTES);
    word_idx = rel[WORD_IDX_W+1:2];
    rd_win   = rd_en && in_win;

    wr_op = OP_NONE;
    if (wr_en && aligned) begin
      if (addr == SEQ_LO_OFS)                 wr_op = OP_SEQ_LO;
      else if (addr == SEQ_HI_OFS)            wr_op = OP_SEQ_HI;
      else if (in_win)                        wr_op = OP_WIN;
      else if (addr == LOAD_OFS && wdata[0])  wr_op = OP_LOAD;
    end
  end

  always_comb begin
    if (wr_en && !aligned)
      AST_UNALIGNED_IGNORED: assert (wr_op == OP_NONE); // R10
  end
endmodule

// File: rtl/dsq_slot_store.sv
module dsq_slot_store
  import dsq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int WORD_IDX_W = $clog2(2 * NUM_SLOTS),
  localparam int PTR_W      = $clog2(NUM_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  dsq_op_e                     wr_op,
  input  logic [WORD_IDX_W-1:0]       word_idx,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           rd_word,
  output logic [NUM_SLOTS*DESC_W-1:0] slots_flat
);
  logic [WORD_W-1:0] slot_lo [NUM_SLOTS];
  logic [WORD_W-1:0] slot_hi [NUM_SLOTS];
  logic [WORD_W-1:0] stage_lo;
  logic [PTR_W-1:0]  ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo <= '0;
      ptr      <= '0;
    end else begin
      if (wr_op == OP_SEQ_LO) stage_lo <= wdata;
      if (wr_op == OP_SEQ_HI)
        ptr <= (ptr == PTR_W'(NUM_SLOTS - 1)) ? '0 : ptr + PTR_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic seq_hit, win_lo, win_hi;
    assign seq_hit = (wr_op == OP_SEQ_HI) && (ptr == PTR_W'(i));
    assign win_lo  = (wr_op == OP_WIN) && (word_idx == WORD_IDX_W'(2 * i));
    assign win_hi  = (wr_op == OP_WIN) && (word_idx == WORD_IDX_W'(2 * i + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_lo[i] <= '0;
        slot_hi[i] <= '0;
      end else begin
        if (seq_hit) begin
          slot_lo[i] <= stage_lo;
          slot_hi[i] <= wdata;
        end
        if (win_lo) slot_lo[i] <= wdata;
        if (win_hi) slot_hi[i] <= wdata;
      end
    end

    assign slots_flat[i*DESC_W +: DESC_W] = {slot_hi[i], slot_lo[i]};
  end

  always_comb begin
    if (word_idx[0]) rd_word = slot_hi[word_idx[WORD_IDX_W-1:1]];
    else             rd_word = slot_lo[word_idx[WORD_IDX_W-1:1]];
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_SEQ_HI && ptr == PTR_W'(NUM_SLOTS - 1)) |=> (ptr == '0)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_SEQ_HI && ptr != PTR_W'(NUM_SLOTS - 1)) |=> (ptr == $past(ptr) + PTR_W'(1))); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op != OP_SEQ_HI) |=> $stable(ptr)); // R3
endmodule

// File: rtl/dsq_load_ctrl.sv
module dsq_load_ctrl
  import dsq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SNAP_W = NUM_SLOTS * DESC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_cmd,
  input  logic [SNAP_W-1:0]    slots_flat,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [SNAP_W-1:0]    out_data,
  output logic [NUM_SLOTS-1:0] out_used
);
  logic pend;
  logic take;
  logic [NUM_SLOTS-1:0] used_now;

  assign take = (load_cmd || pend) && (!out_valid || out_ready);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_used
    assign used_now[i] = |slots_flat[i*DESC_W +: DESC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_used  <= '0;
    end else begin
      if (take) begin
        pend      <= 1'b0;
        out_valid <= 1'b1;
        out_data  <= slots_flat;
        out_used  <= used_now;
      end else begin
        if (load_cmd) pend <= 1'b1;
        if (out_ready) out_valid <= 1'b0;
      end
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_used))); // R7
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cmd && out_valid && !out_ready) |=> pend); // R8
  AST_HANDSHAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load_cmd && !pend) |=> !out_valid); // R7
endmodule

// File: rtl/desc_stage_queue.sv
module desc_stage_queue
  import dsq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 8,
  localparam int WORD_IDX_W = $clog2(2 * NUM_SLOTS),
  localparam int SNAP_W     = NUM_SLOTS * DESC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SNAP_W-1:0]    out_data,
  output logic [NUM_SLOTS-1:0] out_used
);
  dsq_op_e               wr_op;
  logic [WORD_IDX_W-1:0] word_idx;
  logic                  rd_win;
  logic [WORD_W-1:0]     store_rd;
  logic [SNAP_W-1:0]     slots_flat;

  dsq_bus_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_decode (
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr), .wdata(bus_wdata),
    .wr_op(wr_op), .word_idx(word_idx), .rd_win(rd_win)
  );

  dsq_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_op(wr_op), .word_idx(word_idx),
    .wdata(bus_wdata), .rd_word(store_rd), .slots_flat(slots_flat)
  );

  dsq_load_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_load (
    .clk(clk), .rst_n(rst_n), .load_cmd(wr_op == OP_LOAD),
    .slots_flat(slots_flat), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_used(out_used)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_win ? store_rd : '0;
  end

  AST_LOAD_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_LOAD) |=> $stable(slots_flat)); // R6
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_LOAD && !out_valid) |=> (out_valid && out_data == $past(slots_flat))); // R6
  AST_NONWIN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !rd_win) |=> (bus_rdata == '0)); // R5
endmodule

// File: tb/desc_stage_queue_tb.sv
module desc_stage_queue_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         out_valid, out_ready = 1'b0;
  logic [511:0] out_data;
  logic [7:0]   out_used;

  localparam logic [11:0] A_SEQ_LO = 12'h500, A_SEQ_HI = 12'h504;
  localparam logic [11:0] A_WIN = 12'h510, A_LOAD = 12'h550;

  int n_tests = 0, n_fail = 0;
  logic [63:0] exp_slot [8];
  int exp_ptr = 0;

  always #4 clk = ~clk;

  desc_stage_queue u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_used(out_used)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd_en = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_slot(input int n, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd32(A_WIN + 12'(8 * n), lo);
    rd32(A_WIN + 12'(8 * n + 4), hi);
    d = {hi, lo};
  endtask

  task automatic seq_push(input logic [63:0] d);
    wr32(A_SEQ_LO, d[31:0]);
    wr32(A_SEQ_HI, d[63:32]);
    exp_slot[exp_ptr] = d;
    exp_ptr = (exp_ptr + 1) % 8;
  endtask

  task automatic chk_all_slots(input string tag);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      rd_slot(i, v);
      chk(tag, v, exp_slot[i]);
    end
  endtask

  task automatic chk_snapshot(input string tag);
    logic [7:0] used;
    for (int i = 0; i < 8; i++) begin
      chk(tag, out_data[64*i +: 64], exp_slot[i]);
      used[i] = (exp_slot[i] != 64'd0);
    end
    chk({tag, " R9 mask"}, 64'(out_used), 64'(used));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) exp_slot[i] = '0;
    chk("R1 valid", 64'(out_valid), 64'd0);
    chk_all_slots("R1 slots");
  endtask

  task automatic t_sequential;
    for (int i = 0; i < 8; i++) seq_push({32'hA000_0000 + 32'(i), 32'h1111_0000 + 32'(i)});
    chk_all_slots("R2 fill");
    seq_push(64'hBEEF_0009_CAFE_0009);
    chk_all_slots("R2 wrap");
  endtask

  task automatic t_pointer_hold;
    logic [63:0] v;
    wr32(A_SEQ_LO, 32'h5555_AAAA);
    wr32(A_WIN + 12'(8 * 6), 32'h6666_0006);
    exp_slot[6][31:0] = 32'h6666_0006;
    wr32(A_SEQ_HI, 32'h7777_0001);
    exp_slot[1] = 64'h7777_0001_5555_AAAA;
    exp_ptr = 2;
    rd_slot(1, v); chk("R3 slot1 at pointer", v, exp_slot[1]);
    rd_slot(2, v); chk("R3 slot2 untouched", v, exp_slot[2]);
    rd_slot(6, v); chk("R3 window write", v, exp_slot[6]);
  endtask

  task automatic t_window;
    logic [31:0] w;
    wr32(A_WIN + 12'(8 * 5), 32'h0BAD_F00D);
    wr32(A_WIN + 12'(8 * 5 + 4), 32'h1234_5678);
    exp_slot[5] = 64'h1234_5678_0BAD_F00D;
    rd32(A_WIN + 12'(8 * 5 + 4), w); chk("R4 upper", 64'(w), 64'h1234_5678);
    rd32(A_WIN + 12'(8 * 5), w);     chk("R4 lower", 64'(w), 64'h0BAD_F00D);
    wr32(A_WIN + 12'(8 * 7), 32'd0);
    wr32(A_WIN + 12'(8 * 7 + 4), 32'd0);
    exp_slot[7] = '0;
    chk_all_slots("R4 all");
  endtask

  task automatic t_load_basic;
    logic [31:0] w;
    wr32(A_LOAD, 32'hFFFF_FFFE);
    chk("R5 bit0 clear no load", 64'(out_valid), 64'd0);
    rd32(A_SEQ_HI, w); chk("R5 seq read zero", 64'(w), 64'd0);
    wr32(A_LOAD, 32'd1);
    chk("R6 valid after load", 64'(out_valid), 64'd1);
    chk_snapshot("R6 snapshot");
    rd32(A_LOAD, w); chk("R5 load reads zero", 64'(w), 64'd0);
    chk_all_slots("R6 slots kept");
    repeat (3) @(negedge clk);
    chk("R7 held valid", 64'(out_valid), 64'd1);
    chk_snapshot("R7 held data");
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    chk("R7 drop after handshake", 64'(out_valid), 64'd0);
  endtask

  task automatic t_pending;
    wr32(A_LOAD, 32'd1);
    chk("R8 first valid", 64'(out_valid), 64'd1);
    wr32(A_LOAD, 32'd1);
    wr32(A_LOAD, 32'd1);
    wr32(A_WIN + 12'(8 * 2), 32'hDEAD_0002);
    exp_slot[2][31:0] = 32'hDEAD_0002;
    chk("R8 still first", out_data[128 +: 64] == exp_slot[2] ? 64'd1 : 64'd0, 64'd0);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    chk("R8 held load taken", 64'(out_valid), 64'd1);
    chk_snapshot("R8 new snapshot");
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    chk("R8 collapsed to one", 64'(out_valid), 64'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] w;
    wr32(12'h600, 32'hFFFF_FFFF);
    wr32(12'h508, 32'hFFFF_FFFF);
    wr32(A_WIN + 12'd1, 32'hFFFF_FFFF);
    wr32(A_WIN + 12'd66, 32'hFFFF_FFFF);
    wr32(A_LOAD + 12'd2, 32'd1);
    chk("R10 no load", 64'(out_valid), 64'd0);
    chk_all_slots("R10 slots");
    rd32(12'h600, w); chk("R10 read zero", 64'(w), 64'd0);
    rd32(A_WIN + 12'd1, w); chk("R10 unaligned read", 64'(w), 64'd0);
    seq_push(64'h0000_0003_0000_0030);
    chk_all_slots("R10 pointer intact");
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sequential();
    t_pointer_hold();
    t_window();
    t_load_basic();
    t_pending();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule